// File: doc/BRIEF.md
# Zoned Wait-State External Memory Sequencer

This block sits between a processor core and one shared external memory bus. Each instruction can ask for one program-memory access, one data-memory access, or both. The block works out which of these accesses leave the chip. It then runs them on a single 14-bit address bus and a 24-bit data bus, using active-low space selects and active-low read and write strobes. External data memory is split into five fixed address zones. Each zone has its own 3-bit wait count, so slow peripherals and fast memories can share the bus. Program-memory external accesses use one separate wait count.

The sequencer starts the first external cycle in the same cycle that the request arrives, so a lone zero-wait access costs nothing extra. While more bus cycles are still needed, a stall output holds the core. The core must keep its requests steady until stall drops. If an instruction needs both spaces externally, the program access always runs first and the data access follows it. Both wait-count registers are written and read through the data-memory request port. A write reaches the bus on the next instruction's accesses.

Top module: `extmem_seq`

## Requirements
- R1: After reset all selects and strobes are high, both output enables and stall are low. Every wait count is 7, so the zone register reads 0x7FFF and the program register reads 0x0007.
- R2: A data address is in zone 0 for 0x0000..0x03FF, zone 1 for 0x0400..0x07FF, zone 2 for 0x0800..0x2FFF, zone 3 for 0x3000..0x33FF and zone 4 for 0x3400..0x37FF. An external data access lasts 1 + W cycles, where W is that zone's wait count.
- R3: Data addresses at 0x3800 and above, and program addresses below PM_EXT_BASE (0x0800), are internal. They leave both selects, both strobes and both output enables inactive, and they raise no stall.
- R4: An external program access lasts 1 + P cycles, where P is bits 2:0 of the register at data address 0x3FFF.
- R5: For the whole access the select of the active space stays low and the address stays driven and constant. mem_rd_n is low for a read and mem_wr_n is low for a write, never both at once.
- R6: When an instruction needs both spaces externally, all program cycles come first and the data cycles follow directly. With zero waits this takes two cycles.
- R7: Stall is high in every cycle of an instruction's external work except the last one. A single zero-wait access therefore raises no stall.
- R8: Data-space values use bus lines 23:8 (write data is {dm_wdata, 8'h00}). Program values use all 24 lines. Read data is registered, with its valid pulse one cycle after the final access cycle.
- R9: Writing data address 0x3FFE loads the zone counts: zone 0 in bits 2:0, zone 1 in 5:3, zone 2 in 8:6, zone 3 in 11:9 and zone 4 in 14:12. Writing 0x3FFF loads the program count from bits 2:0. A read of either address returns the register, with a valid pulse on the next cycle. A new value governs the next instruction's accesses and not the accesses of the instruction that writes it.
- R10: At most one space select is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_req | input | 1 | Program-memory access request for this instruction |
| pm_we | input | 1 | Program access is a write |
| pm_addr | input | 14 | Program-memory address |
| pm_wdata | input | 24 | Program write data |
| pm_rdata | output | 24 | Registered program read data |
| pm_rvalid | output | 1 | Pulse: pm_rdata updated |
| dm_req | input | 1 | Data-memory access request for this instruction |
| dm_we | input | 1 | Data access is a write |
| dm_addr | input | 14 | Data-memory address |
| dm_wdata | input | 16 | Data write data |
| dm_rdata | output | 16 | Registered data read value |
| dm_rvalid | output | 1 | Pulse: dm_rdata updated |
| stall | output | 1 | Core must hold its requests |
| ext_addr | output | 14 | External address bus |
| ext_addr_oe | output | 1 | Address bus and selects driven |
| ext_wdata | output | 24 | External data bus, outgoing |
| ext_data_oe | output | 1 | Data bus driven by this block |
| ext_rdata | input | 24 | External data bus, incoming |
| pm_sel_n | output | 1 | Program space select, active low |
| dm_sel_n | output | 1 | Data space select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The properties assume that the core keeps both request sets steady, including address, direction and data, in every cycle that follows a cycle with stall high. They also assume the core changes its requests only once an instruction has finished. The bench applies each instruction at a falling edge and holds it until it sees the cycle in which stall is low, then clears the requests. It mixes random zone, space and direction choices with random register writes inside that discipline. Directed cases cover every zone edge, the internal boundaries, zero-wait overlap and a register write that shares an instruction with a program fetch.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

    localparam int ADDR_W = 14;
    localparam int PM_W   = 24;
    localparam int DM_W   = 16;
    localparam int WAIT_W = 3;
    localparam int NZONE  = 5;
    localparam int ZIDX_W = $clog2(NZONE);
    localparam int ZBITS  = NZONE * WAIT_W;
    localparam int DM_LSB = PM_W - DM_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WAIT_W-1:0] wait_t;

    typedef enum logic [1:0] {ST_IDLE, ST_PM, ST_DM} seq_state_e;
    typedef enum logic [1:0] {SP_NONE, SP_PM, SP_DM} space_e;

    typedef struct packed {
        logic              ext;
        logic [ZIDX_W-1:0] zone;
    } dm_dec_t;

    localparam addr_t ZONE_LAST [NZONE] = '{14'h03FF, 14'h07FF, 14'h2FFF, 14'h33FF, 14'h37FF};
    localparam addr_t CFG_ZONE_ADDR = 14'h3FFE;
    localparam addr_t CFG_PM_ADDR   = 14'h3FFF;

    // Lowest zone whose upper bound covers the address wins.
    function automatic dm_dec_t decode_dm(input addr_t a);
        dm_dec_t d;
        d.ext  = 1'b0;
        d.zone = '0;
        for (int i = NZONE - 1; i >= 0; i--) begin
            if (a <= ZONE_LAST[i]) begin
                d.ext  = 1'b1;
                d.zone = ZIDX_W'(i);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/extmem_zone_dec.sv
module extmem_zone_dec
    import extmem_pkg::*;
(
    input  addr_t             addr,
    output logic              ext,
    output logic [ZIDX_W-1:0] zone
);
    dm_dec_t dec;

    always_comb begin
        dec  = decode_dm(addr);
        ext  = dec.ext;
        zone = dec.zone;
    end
endmodule

// File: rtl/extmem_waitcfg.sv
module extmem_waitcfg
    import extmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_pm,
    input  logic [ZBITS-1:0]  wdata,
    input  logic [ZIDX_W-1:0] zone_sel,
    output wait_t             zone_wait,
    output wait_t             pm_wait,
    output logic [DM_W-1:0]   zone_word,
    output logic [DM_W-1:0]   pm_word
);
    logic [ZBITS-1:0] zpack;
    wait_t            pw_q;

    for (genvar i = 0; i < NZONE; i++) begin : g_zone
        wait_t zw_q;
        always_ff @(posedge clk) begin
            if (rst)
                zw_q <= '1;
            else if (wr_en && !wr_pm)
                zw_q <= wdata[i*WAIT_W +: WAIT_W];
        end
        assign zpack[i*WAIT_W +: WAIT_W] = zw_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pw_q <= '1;
        else if (wr_en && wr_pm)
            pw_q <= wdata[WAIT_W-1:0];
    end

    always_comb begin
        zone_wait = '0;
        if (int'(zone_sel) < NZONE)
            zone_wait = zpack[zone_sel*WAIT_W +: WAIT_W];
        pm_wait   = pw_q;
        zone_word = DM_W'(zpack);
        pm_word   = DM_W'(pw_q);
    end
endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
    import extmem_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pm_go,
    input  logic   dm_go,
    input  wait_t  pm_wait,
    input  wait_t  dm_wait,
    output space_e cur,
    output logic   last,
    output logic   stall
);
    seq_state_e st_q, st_d;
    wait_t      cnt_q, cnt_d;
    wait_t      rem;

    always_comb begin
        cur = SP_NONE;
        rem = '0;
        unique case (st_q)
            ST_IDLE: begin
                if (pm_go) begin
                    cur = SP_PM;
                    rem = pm_wait;
                end else if (dm_go) begin
                    cur = SP_DM;
                    rem = dm_wait;
                end
            end
            ST_PM: begin
                cur = SP_PM;
                rem = cnt_q;
            end
            ST_DM: begin
                cur = SP_DM;
                rem = cnt_q;
            end
            default: ;
        endcase
        last = (rem == '0);

        st_d  = ST_IDLE;
        cnt_d = '0;
        if (cur == SP_PM) begin
            if (!last) begin
                st_d  = ST_PM;
                cnt_d = rem - 1'b1;
            end else if (dm_go) begin
                st_d  = ST_DM;
                cnt_d = dm_wait;
            end
        end else if (cur == SP_DM && !last) begin
            st_d  = ST_DM;
            cnt_d = rem - 1'b1;
        end

        stall = (cur != SP_NONE) && !(last && (cur == SP_DM || !dm_go));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
    import extmem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PM_EXT_BASE = 14'h0800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pm_req,
    input  logic              pm_we,
    input  logic [ADDR_W-1:0] pm_addr,
    input  logic [PM_W-1:0]   pm_wdata,
    output logic [PM_W-1:0]   pm_rdata,
    output logic              pm_rvalid,
    input  logic              dm_req,
    input  logic              dm_we,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic [DM_W-1:0]   dm_wdata,
    output logic [DM_W-1:0]   dm_rdata,
    output logic              dm_rvalid,
    output logic              stall,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              ext_addr_oe,
    output logic [PM_W-1:0]   ext_wdata,
    output logic              ext_data_oe,
    input  logic [PM_W-1:0]   ext_rdata,
    output logic              pm_sel_n,
    output logic              dm_sel_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n
);
    logic              dm_ext;
    logic [ZIDX_W-1:0] dm_zone;
    wait_t             zone_wait, pm_wait;
    logic [DM_W-1:0]   zone_word, pm_word;
    logic              pm_go, dm_go;
    space_e            cur;
    logic              last;
    logic              cfg_hit, cfg_pm, cfg_wr, cfg_rd, cur_we;

    extmem_zone_dec u_dec (
        .addr (dm_addr),
        .ext  (dm_ext),
        .zone (dm_zone)
    );

    assign pm_go   = pm_req && (pm_addr >= PM_EXT_BASE);
    assign dm_go   = dm_req && dm_ext;
    assign cfg_pm  = (dm_addr == CFG_PM_ADDR);
    assign cfg_hit = (dm_addr == CFG_ZONE_ADDR) || cfg_pm;
    // Register access completes with the instruction (its non-stalled cycle).
    assign cfg_wr  = dm_req && dm_we && cfg_hit && !stall;
    assign cfg_rd  = dm_req && !dm_we && cfg_hit && !stall;

    extmem_waitcfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .wr_pm     (cfg_pm),
        .wdata     (dm_wdata[ZBITS-1:0]),
        .zone_sel  (dm_zone),
        .zone_wait (zone_wait),
        .pm_wait   (pm_wait),
        .zone_word (zone_word),
        .pm_word   (pm_word)
    );

    extmem_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .pm_go   (pm_go),
        .dm_go   (dm_go),
        .pm_wait (pm_wait),
        .dm_wait (zone_wait),
        .cur     (cur),
        .last    (last),
        .stall   (stall)
    );

    always_comb begin
        ext_addr    = '0;
        ext_wdata   = '0;
        cur_we      = 1'b0;
        unique case (cur)
            SP_PM: begin
                ext_addr  = pm_addr;
                ext_wdata = pm_wdata;
                cur_we    = pm_we;
            end
            SP_DM: begin
                ext_addr  = dm_addr;
                ext_wdata = {dm_wdata, {DM_LSB{1'b0}}};
                cur_we    = dm_we;
            end
            default: ;
        endcase
        ext_addr_oe = (cur != SP_NONE);
        ext_data_oe = ext_addr_oe && cur_we;
        pm_sel_n    = (cur != SP_PM);
        dm_sel_n    = (cur != SP_DM);
        mem_rd_n    = !(ext_addr_oe && !cur_we);
        mem_wr_n    = !(ext_addr_oe && cur_we);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_rdata  <= '0;
            pm_rvalid <= 1'b0;
            dm_rdata  <= '0;
            dm_rvalid <= 1'b0;
        end else begin
            pm_rvalid <= 1'b0;
            dm_rvalid <= 1'b0;
            if (cur == SP_PM && last && !pm_we) begin
                pm_rdata  <= ext_rdata;
                pm_rvalid <= 1'b1;
            end
            if (cur == SP_DM && last && !dm_we) begin
                dm_rdata  <= ext_rdata[PM_W-1:DM_LSB];
                dm_rvalid <= 1'b1;
            end
            if (cfg_rd) begin
                dm_rdata  <= cfg_pm ? pm_word : zone_word;
                dm_rvalid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/extmem_seq_chk.sv
module extmem_seq_chk
    import extmem_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PM_EXT_BASE = 14'h0800
) (
    input logic              clk,
    input logic              rst,
    input logic              pm_req,
    input logic [ADDR_W-1:0] pm_addr,
    input logic              dm_req,
    input logic [ADDR_W-1:0] dm_addr,
    input logic              stall,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              ext_addr_oe,
    input logic              pm_sel_n,
    input logic              dm_sel_n,
    input logic              mem_rd_n,
    input logic              mem_wr_n
);
    assert_one_select_R10: assert property (@(posedge clk) disable iff (rst)
        !(!pm_sel_n && !dm_sel_n));

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    assert_strobe_inside_select_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd_n || !mem_wr_n) |-> ((!pm_sel_n || !dm_sel_n) && ext_addr_oe));

    assert_addr_steady_R5: assert property (@(posedge clk) disable iff (rst)
        (!pm_sel_n && $past(!pm_sel_n) && $past(stall)) |-> $stable(ext_addr));

    assert_pm_first_R6: assert property (@(posedge clk) disable iff (rst)
        (!pm_sel_n && $past(!dm_sel_n)) |-> $past(!stall));

    assert_stall_needs_bus_R7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!pm_sel_n || !dm_sel_n));

    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pm_req) && $stable(dm_req) && $stable(pm_addr) && $stable(dm_addr)));

    assert_dm_external_only_R3: assert property (@(posedge clk) disable iff (rst)
        !dm_sel_n |-> (ext_addr < 14'h3800));

    assert_pm_external_only_R3: assert property (@(posedge clk) disable iff (rst)
        !pm_sel_n |-> (ext_addr >= PM_EXT_BASE));
endmodule

bind extmem_seq extmem_seq_chk #(.PM_EXT_BASE(PM_EXT_BASE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pm_req      (pm_req),
    .pm_addr     (pm_addr),
    .dm_req      (dm_req),
    .dm_addr     (dm_addr),
    .stall       (stall),
    .ext_addr    (ext_addr),
    .ext_addr_oe (ext_addr_oe),
    .pm_sel_n    (pm_sel_n),
    .dm_sel_n    (dm_sel_n),
    .mem_rd_n    (mem_rd_n),
    .mem_wr_n    (mem_wr_n)
);

// File: tb/sim_extmem_seq.sv
`timescale 1ns/1ps
module sim_extmem_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        pm_req, pm_we, dm_req, dm_we;
    logic [13:0] pm_addr, dm_addr, ext_addr;
    logic [23:0] pm_wdata, pm_rdata, ext_wdata, ext_rdata;
    logic [15:0] dm_wdata, dm_rdata;
    logic        pm_rvalid, dm_rvalid, stall, ext_addr_oe, ext_data_oe;
    logic        pm_sel_n, dm_sel_n, mem_rd_n, mem_wr_n;

    int n_chk = 0;
    int n_fail = 0;
    logic [2:0] zw_m [5];
    logic [2:0] pw_m;

    always #2.5 clk = ~clk;

    extmem_seq u0 (
        .clk(clk), .rst(rst),
        .pm_req(pm_req), .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata),
        .pm_rdata(pm_rdata), .pm_rvalid(pm_rvalid),
        .dm_req(dm_req), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .dm_rvalid(dm_rvalid),
        .stall(stall), .ext_addr(ext_addr), .ext_addr_oe(ext_addr_oe),
        .ext_wdata(ext_wdata), .ext_data_oe(ext_data_oe), .ext_rdata(ext_rdata),
        .pm_sel_n(pm_sel_n), .dm_sel_n(dm_sel_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
    );

    function automatic logic [23:0] mem_val(input logic [13:0] a);
        return {a[7:0] ^ 8'hA5, a, 2'b10};
    endfunction

    assign ext_rdata = mem_val(ext_addr);

    function automatic logic [2:0] zone_wait_m(input logic [13:0] a);
        if (a <= 14'h03FF) return zw_m[0];
        if (a <= 14'h07FF) return zw_m[1];
        if (a <= 14'h2FFF) return zw_m[2];
        if (a <= 14'h33FF) return zw_m[3];
        return zw_m[4];
    endfunction

    function automatic logic [15:0] zone_word_m();
        return {1'b0, zw_m[4], zw_m[3], zw_m[2], zw_m[1], zw_m[0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] bus_vec();
        return {11'd0, pm_sel_n, dm_sel_n, mem_rd_n, mem_wr_n, stall, ext_addr_oe, ext_data_oe, ext_addr};
    endfunction

    task automatic do_instr(input string tag,
                            input logic pr, input logic pw, input logic [13:0] pa, input logic [23:0] pd,
                            input logic dr, input logic dw, input logic [13:0] da, input logic [15:0] dd);
        int npm, ndm, n, ncyc;
        logic inpm, we;
        logic [31:0] e;
        npm = (pr && pa >= 14'h0800) ? 1 + int'(pw_m) : 0;
        ndm = (dr && da < 14'h3800) ? 1 + int'(zone_wait_m(da)) : 0;
        n = npm + ndm;
        ncyc = (n == 0) ? 1 : n;
        @(negedge clk);
        pm_req = pr; pm_we = pw; pm_addr = pa; pm_wdata = pd;
        dm_req = dr; dm_we = dw; dm_addr = da; dm_wdata = dd;
        for (int k = 0; k < ncyc; k++) begin
            #1;
            if (n == 0) begin
                e = {11'd0, 7'b1111000, 14'd0};
                chk({tag, " idle bus"}, bus_vec(), e);
            end else begin
                inpm = (k < npm);
                we = inpm ? pw : dw;
                e = {11'd0, !inpm, inpm, we, !we, (k < n - 1), 1'b1, we, (inpm ? pa : da)};
                chk({tag, " bus cycle"}, bus_vec(), e);
                if (we)
                    chk("R8 write data", {8'd0, ext_wdata}, {8'd0, (inpm ? pd : {dd, 8'h00})});
            end
            @(negedge clk);
        end
        #1;
        if (npm > 0 && !pw) begin
            chk("R8 pm read data", {8'd0, pm_rdata}, {8'd0, mem_val(pa)});
            if (ndm == 0) chk("R8 pm rvalid", {31'd0, pm_rvalid}, 32'd1);
        end
        if (ndm > 0 && !dw) begin
            chk("R8 dm read data", {16'd0, dm_rdata}, {16'd0, mem_val(da)[23:8]});
            chk("R8 dm rvalid", {31'd0, dm_rvalid}, 32'd1);
        end
        if (dr && !dw && (da == 14'h3FFE || da == 14'h3FFF)) begin
            chk("R9 register read", {16'd0, dm_rdata},
                {16'd0, (da == 14'h3FFE) ? zone_word_m() : {13'd0, pw_m}});
            chk("R9 register rvalid", {31'd0, dm_rvalid}, 32'd1);
        end
        if (dr && dw && da == 14'h3FFE)
            for (int i = 0; i < 5; i++) zw_m[i] = dd[3*i +: 3];
        if (dr && dw && da == 14'h3FFF)
            pw_m = dd[2:0];
        pm_req = 0; dm_req = 0; pm_we = 0; dm_we = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1;
        pm_req = 0; pm_we = 0; pm_addr = 0; pm_wdata = 0;
        dm_req = 0; dm_we = 0; dm_addr = 0; dm_wdata = 0;
        for (int i = 0; i < 5; i++) zw_m[i] = 3'd7;
        pw_m = 3'd7;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: idle after reset
        chk("R1 reset bus", bus_vec(), {11'd0, 7'b1111000, 14'd0});
        chk("R1 reset rvalid", {30'd0, pm_rvalid, dm_rvalid}, 32'd0);
        do_instr("R1", 0, 0, 0, 0, 1, 0, 14'h3FFE, 0);
        do_instr("R1", 0, 0, 0, 0, 1, 0, 14'h3FFF, 0);
        // R2 / R7: default seven waits, eight cycles
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h0123, 0);
        // R9: program distinct zone counts
        do_instr("R9", 0, 0, 0, 0, 1, 1, 14'h3FFE, 16'h4688);
        do_instr("R9", 0, 0, 0, 0, 1, 0, 14'h3FFE, 0);
        // R2: zone edges
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h0000, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h03FF, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h0400, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h07FF, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h0800, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h2FFF, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h3000, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h33FF, 0);
        do_instr("R2", 0, 0, 0, 0, 1, 0, 14'h3400, 0);
        do_instr("R5", 0, 0, 0, 0, 1, 1, 14'h37FF, 16'hBEEF);
        // R3: internal boundaries
        do_instr("R3", 0, 0, 0, 0, 1, 0, 14'h3800, 0);
        do_instr("R3", 1, 0, 14'h07FF, 0, 0, 0, 0, 0);
        // R4: program count default 7
        do_instr("R4", 1, 0, 14'h0800, 0, 0, 0, 0, 0);
        do_instr("R4", 0, 0, 0, 0, 1, 1, 14'h3FFF, 16'h0000);
        // R7: zero-wait single access, no stall
        do_instr("R7", 1, 1, 14'h1234, 24'hC0FFEE, 0, 0, 0, 0);
        // R6: zero-wait dual, program first
        do_instr("R6", 1, 0, 14'h2000, 0, 1, 0, 14'h0010, 0);
        do_instr("R6", 1, 1, 14'h3FFF, 24'h123456, 1, 1, 14'h1000, 16'h9ABC);
        // R9: write of program count in same instruction as fetch
        do_instr("R9", 0, 0, 0, 0, 1, 1, 14'h3FFF, 16'h0002);
        do_instr("R9", 1, 0, 14'h0900, 0, 1, 1, 14'h3FFF, 16'h0005);
        do_instr("R9", 1, 0, 14'h0901, 0, 0, 0, 0, 0);
        do_instr("R9", 0, 0, 0, 0, 1, 0, 14'h3FFF, 0);
        // R10 / R5 / R8: random mix
        for (int t = 0; t < 400; t++) begin
            logic [13:0] pa, da;
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 9));
            if (sel == 0) begin
                do_instr("R9", 0, 0, 0, 0, 1, 1, 14'h3FFE, 16'($urandom));
            end else if (sel == 1) begin
                do_instr("R9", 0, 0, 0, 0, 1, 1, 14'h3FFF, 16'($urandom));
            end else begin
                pa = 14'($urandom);
                da = ($urandom_range(0, 7) == 0) ? 14'h3800 + 14'($urandom_range(0, 16'h07FD))
                                                 : 14'($urandom_range(0, 16'h37FF));
                do_instr("R10", 1'($urandom), 1'($urandom), pa, 24'($urandom),
                         1'($urandom), 1'($urandom), da, 16'($urandom));
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule